// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification Unit

This block sits between the event logic of a UART (receiver, transmitter and modem-status sections) and the host. It takes four interrupt sources and gates each one with its own bit in a small enable register. It then selects the single most urgent active source and presents it as a read-only identification byte. A single interrupt line tells the host that at least one enabled source needs service.

The host reads the identification byte to learn which source to service. The byte carries an active-low "pending" flag, a two-bit source code, a flag that marks a receive character timeout, and two bits that mirror whether the FIFOs are on. The line-status, data-available and modem-status sources are levels held by their own logic. The transmitter-empty source is latched inside this block. It clears itself when the host reads the identification byte while that source is the one being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00. A write stores bits 3:0: bit 0 = data available, bit 1 = transmitter empty, bit 2 = line status, bit 3 = modem status. Bits 7:4 always read back as 0.
- R2: Identification bit 0 is 0 when an interrupt is pending and 1 when none is. With nothing pending, bits 3:1 read 000, so the byte after reset is 0x01.
- R3: Identification bits 2:1 name the reported source: 11 line status, 10 data available, 01 transmitter empty, 00 modem status.
- R4: When several enabled sources are active, the reported one is line status first, then data available, then transmitter empty, then modem status.
- R5: A source whose enable bit is 0 is never reported and does not raise the interrupt line.
- R6: Identification bit 3 is 1 only when the data-available code is reported and the character-timeout input is high. Otherwise it is 0.
- R7: Identification bits 7:6 read 11 while the FIFO-enable input is high and 00 while it is low. Bits 5:4 read 0.
- R8: The data-available source is active while the receive-trigger-reached input is high or the timeout input is high.
- R9: A transmitter-empty pulse latches that source. A read of the identification byte clears it only if that read returns the transmitter-empty code. A read that returns another source leaves it latched. An empty pulse in the same cycle as a clearing read wins.
- R10: Writing the enable register so that bit 1 goes from 0 to 1 latches the transmitter-empty source. A write that leaves bit 1 at 1 does not.
- R11: The interrupt output is high exactly when some enabled source is active, which is exactly when identification bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read-back |
| fifo_on | input | 1 | FIFOs enabled |
| lsr_evt | input | 1 | Receiver line-status condition (level) |
| rx_trig | input | 1 | Receive FIFO at or above its trigger level |
| rx_tmo | input | 1 | Receive character timeout (level) |
| thr_empty_pulse | input | 1 | One-cycle pulse: transmit holding register became empty |
| msr_evt | input | 1 | Modem status change (level) |
| iid_rd | input | 1 | Read strobe of the identification byte |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The sources are first raised one at a time from the lowest priority to the highest, so that each new source must pre-empt the one below it. This tells a wrong priority order apart from a wrong source code. Timeout is raised together with data available and then under a line-status condition, which shows whether bit 3 follows the reported code or only the raw input. Identification reads are issued both while the transmitter-empty source is reported and while it is hidden behind a higher source, which separates a correct conditional clear from an unconditional one. Enable writes with bit 1 rising and with bit 1 already set show whether the re-arm follows the edge or the level.

// File: rtl/uart_irq_ident_pkg.sv
package uart_irq_ident_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned NSRC   = 4;

    // Two-bit source identification codes
    typedef enum logic [1:0] {
        SRC_MS  = 2'b00,
        SRC_THR = 2'b01,
        SRC_RDA = 2'b10,
        SRC_LS  = 2'b11
    } src_e;

    // Gated source activity, one flag per source
    typedef struct packed {
        logic ls;
        logic rda;
        logic thr;
        logic ms;
    } src_vec_t;

    // Result of the priority selection
    typedef struct packed {
        logic pend;
        src_e code;
        logic tmo;
    } sel_t;

    // Build the identification byte from the selection and FIFO state
    function automatic logic [DATA_W-1:0] pack_iid(sel_t s, logic fifo);
        return {{2{fifo}}, 2'b00, s.tmo, s.code, ~s.pend};
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_ident_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NB = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [NB-1:0] en,
    output logic [DW-1:0] rdata,
    output logic          thr_rearm
);
    localparam int unsigned PAD_W   = DW - NB;
    localparam int unsigned THR_BIT = 1;

    logic [NB-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr)
            en_q <= wdata[NB-1:0];
    end

    assign en        = en_q;
    assign rdata     = {{PAD_W{1'b0}}, en_q};
    assign thr_rearm = wr && wdata[THR_BIT] && !en_q[THR_BIT];

endmodule

// File: rtl/uart_irq_thr_flag.sv
module uart_irq_thr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rearm,
    input  logic clr,
    output logic pend
);
    logic pend_q;

    // Set beats clear when both land in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (set_evt || rearm)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end

    assign pend = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_ident_pkg::*;
(
    input  src_vec_t act,
    input  logic     tmo,
    output sel_t     sel
);
    always_comb begin
        sel = '{pend: 1'b0, code: SRC_MS, tmo: 1'b0};
        if (act.ls) begin
            sel.pend = 1'b1;
            sel.code = SRC_LS;
        end else if (act.rda) begin
            sel.pend = 1'b1;
            sel.code = SRC_RDA;
            sel.tmo  = tmo;
        end else if (act.thr) begin
            sel.pend = 1'b1;
            sel.code = SRC_THR;
        end else if (act.ms) begin
            sel.pend = 1'b1;
            sel.code = SRC_MS;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_ident_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_wdata,
    output logic [DATA_W-1:0] en_rdata,
    input  logic              fifo_on,
    input  logic              lsr_evt,
    input  logic              rx_trig,
    input  logic              rx_tmo,
    input  logic              thr_empty_pulse,
    input  logic              msr_evt,
    input  logic              iid_rd,
    output logic [DATA_W-1:0] iid,
    output logic              irq
);
    localparam int unsigned EN_RDA = 0;
    localparam int unsigned EN_THR = 1;
    localparam int unsigned EN_LS  = 2;
    localparam int unsigned EN_MS  = 3;

    logic [NSRC-1:0] en;
    logic            thr_rearm;
    logic            thr_pend;
    logic            thr_clr;
    src_vec_t        act;
    sel_t            sel;

    uart_irq_enable #(.DW(DATA_W), .NB(NSRC)) u_enable (
        .clk       (clk),
        .rst       (rst),
        .wr        (en_wr),
        .wdata     (en_wdata),
        .en        (en),
        .rdata     (en_rdata),
        .thr_rearm (thr_rearm)
    );

    uart_irq_thr_flag u_thr (
        .clk     (clk),
        .rst     (rst),
        .set_evt (thr_empty_pulse),
        .rearm   (thr_rearm),
        .clr     (thr_clr),
        .pend    (thr_pend)
    );

    always_comb begin
        act.ls  = en[EN_LS]  && lsr_evt;
        act.rda = en[EN_RDA] && (rx_trig || rx_tmo);
        act.thr = en[EN_THR] && thr_pend;
        act.ms  = en[EN_MS]  && msr_evt;
    end

    uart_irq_prio u_prio (
        .act (act),
        .tmo (rx_tmo),
        .sel (sel)
    );

    assign thr_clr = iid_rd && sel.pend && (sel.code == SRC_THR);
    assign iid     = pack_iid(sel, fifo_on);
    assign irq     = |act;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_wr,
    input logic [7:0] en_rdata,
    input logic       fifo_on,
    input logic       lsr_evt,
    input logic       thr_empty_pulse,
    input logic       iid_rd,
    input logic [7:0] iid,
    input logic       irq
);
    // R11
    a_r11_irq_vs_pending: assert property (@(posedge clk) disable iff (rst)
        irq == !iid[0]);

    // R7
    a_r7_fifo_bits: assert property (@(posedge clk) disable iff (rst)
        (iid[7:6] == {2{fifo_on}}) && (iid[5:4] == 2'b00));

    // R1
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        en_rdata[7:4] == 4'h0);

    // R4
    a_r4_ls_first: assert property (@(posedge clk) disable iff (rst)
        (en_rdata[2] && lsr_evt) |-> (iid[3:0] == 4'b0110));

    // R6
    a_r6_tmo_with_rda: assert property (@(posedge clk) disable iff (rst)
        iid[3] |-> (iid[2:0] == 3'b100));

    // R9
    a_r9_read_clears_thr: assert property (@(posedge clk) disable iff (rst)
        (iid_rd && iid[3:0] == 4'b0010 && !thr_empty_pulse && !en_wr)
        |=> (iid[2:0] != 3'b010));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .en_wr           (en_wr),
    .en_rdata        (en_rdata),
    .fifo_on         (fifo_on),
    .lsr_evt         (lsr_evt),
    .thr_empty_pulse (thr_empty_pulse),
    .iid_rd          (iid_rd),
    .iid             (iid),
    .irq             (irq)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic [7:0] en_rdata;
    logic       fifo_on = 1'b0;
    logic       lsr_evt = 1'b0;
    logic       rx_trig = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       thr_empty_pulse = 1'b0;
    logic       msr_evt = 1'b0;
    logic       iid_rd = 1'b0;
    logic [7:0] iid;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [7:0] iid;
        logic       irq;
        logic [7:0] en;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .fifo_on(fifo_on), .lsr_evt(lsr_evt),
        .rx_trig(rx_trig), .rx_tmo(rx_tmo), .thr_empty_pulse(thr_empty_pulse),
        .msr_evt(msr_evt), .iid_rd(iid_rd), .iid(iid), .irq(irq)
    );

    // Expected identification byte from the requirement fields
    function automatic logic [7:0] mk(logic fifo, logic pend, logic [1:0] code, logic tmo);
        return {{2{fifo}}, 2'b00, tmo, code, ~pend};
    endfunction

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (iid !== e.iid || irq !== e.irq || en_rdata !== e.en) begin
                    n_fail++;
                    $display("FAIL %s: iid=%h irq=%b en=%h expected iid=%h irq=%b en=%h",
                             e.tag, iid, irq, en_rdata, e.iid, e.irq, e.en);
                end
            end
        end
    end

    task automatic expect_out(logic [7:0] ei, logic eq, logic [7:0] ee, string tag);
        exp_t e;
        e.iid = ei; e.irq = eq; e.en = ee; e.tag = tag;
        exp_q.push_back(e);
        #1;
    endtask

    task automatic wr_en(logic [7:0] d);
        @(negedge clk); en_wr = 1'b1; en_wdata = d;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic pulse_thr();
        @(negedge clk); thr_empty_pulse = 1'b1;
        @(negedge clk); thr_empty_pulse = 1'b0;
    endtask

    task automatic rd_iid();
        @(negedge clk); iid_rd = 1'b1;
        @(negedge clk); iid_rd = 1'b0;
    endtask

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out(8'h01, 1'b0, 8'h00, "R2 reset idle byte");

        wr_en(8'hFF);
        expect_out(mk(0,1,2'b01,0), 1'b1, 8'h0F, "R1 R10 write FF, thr rearmed");

        rd_iid();
        expect_out(8'h01, 1'b0, 8'h0F, "R9 read clears thr");

        @(negedge clk); msr_evt = 1'b1;
        expect_out(mk(0,1,2'b00,0), 1'b1, 8'h0F, "R3 modem code");

        pulse_thr();
        expect_out(mk(0,1,2'b01,0), 1'b1, 8'h0F, "R4 thr over modem");

        @(negedge clk); rx_trig = 1'b1;
        expect_out(mk(0,1,2'b10,0), 1'b1, 8'h0F, "R8 trigger gives data available");

        @(negedge clk); rx_tmo = 1'b1;
        expect_out(mk(0,1,2'b10,1), 1'b1, 8'h0F, "R6 timeout flag");

        @(negedge clk); fifo_on = 1'b1;
        expect_out(mk(1,1,2'b10,1), 1'b1, 8'h0F, "R7 fifo bits on");

        @(negedge clk); lsr_evt = 1'b1;
        expect_out(mk(1,1,2'b11,0), 1'b1, 8'h0F, "R4 R6 line status top, no tmo flag");

        rd_iid();
        @(negedge clk); lsr_evt = 1'b0; rx_trig = 1'b0; rx_tmo = 1'b0;
        expect_out(mk(1,1,2'b01,0), 1'b1, 8'h0F, "R9 hidden read keeps thr");

        @(negedge clk); rx_tmo = 1'b1;
        expect_out(mk(1,1,2'b10,1), 1'b1, 8'h0F, "R8 timeout alone gives data available");
        @(negedge clk); rx_tmo = 1'b0;

        wr_en(8'h01);
        @(negedge clk); rx_trig = 1'b1;
        expect_out(mk(1,1,2'b10,0), 1'b1, 8'h01, "R5 only data available enabled");
        @(negedge clk); rx_trig = 1'b0;
        expect_out(8'hC1, 1'b0, 8'h01, "R5 disabled thr and modem silent");

        wr_en(8'h03);
        expect_out(mk(1,1,2'b01,0), 1'b1, 8'h03, "R10 rearm on bit1 rise");
        rd_iid();
        expect_out(8'hC1, 1'b0, 8'h03, "R9 clear after rearm");

        wr_en(8'h03);
        expect_out(8'hC1, 1'b0, 8'h03, "R10 no rearm when bit1 stays set");

        @(negedge clk); fifo_on = 1'b0;
        expect_out(8'h01, 1'b0, 8'h03, "R7 R11 fifo bits off, irq low");

        // Empty pulse and clearing read in the same cycle: set wins
        pulse_thr();
        @(negedge clk); iid_rd = 1'b1; thr_empty_pulse = 1'b1;
        @(negedge clk); iid_rd = 1'b0; thr_empty_pulse = 1'b0;
        expect_out(mk(0,1,2'b01,0), 1'b1, 8'h03, "R9 set beats clear");

        wait (exp_q.size() == 0);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule